// File: doc/BRIEF.md
# Deskew Training Sequencer for a Seven-to-One Serial Link

This block feeds the parallel side of a 7:1 serializer that drives a source-synchronous differential link with a group of data lanes and one forwarded clock lane. Each forwarded-clock cycle carries seven serial bit times per lane. For that reason the block produces one 7-bit word per lane, plus one for the clock lane, on every cycle.

The transmit PLL raises a lock flag. Once the sequencer sees that flag, it sends a deskew calibration pattern for a fixed number of cycles. The receiver needs this pattern to align its sampling strobe on each lane. After the pattern, the sequencer passes the parallel payload through unchanged.

A mode input selects one of two training patterns. A shape input picks between two variants of each pattern. Training starts again whenever lock is lost or a restart is requested, for example after a cable swap. A power-down input disables the output drivers and sends the sequencer back to its idle state.

Top module: `deskew_train_seq`

## Requirements
- R1: While reset is held, and from the first clock edge at which `pwr_n` is sampled low, `drv_en` is 0, `train_busy` is 0, and every lane word and the clock word are all zeros.
- R2: With power on and lock not yet seen, `drv_en` is 1, `train_busy` is 0, and the data words are zero. The clock word is the idle word: 1111000 when `shape_sel`=0, 1110000 when `shape_sel`=1. Training begins on the cycle after `pll_lock` is first sampled high.
- R3: `train_busy` stays high for exactly TRAIN_CYCLES consecutive cycles. On the next cycle the sequencer enters payload mode.
- R4: With `mode_sel`=1 during training, the clock word is the idle word selected by `shape_sel`. Every data word is 1111111 on training cycle k for even k (the first training cycle is k=0) and 0000000 for odd k.
- R5: With `mode_sel`=0 during training, the clock word is 1111100 (`shape_sel`=0) or 1100000 (`shape_sel`=1). Every data word is 1111000 (`shape_sel`=0) or 1110000 (`shape_sel`=1).
- R6: In payload mode, lane word i equals `payload[7*i+6:7*i]`, and bit 6 is the first bit on the wire. The clock word is the idle word selected by `shape_sel`.
- R7: When `pll_lock` is sampled low during training or payload mode, `train_busy` is 0 and the data words are zero on the next cycle. After lock returns, a complete training run of TRAIN_CYCLES cycles follows.
- R8: When `restart` is sampled high during training or payload mode, the sequencer returns to waiting for lock. It then repeats a complete training run.
- R9: During training, the serial stream of every data lane contains a bit transition within any three consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_n | input | 1 | Low requests power-down |
| pll_lock | input | 1 | Transmit PLL lock flag |
| restart | input | 1 | Request to repeat training |
| mode_sel | input | 1 | 1: alternating data pattern, 0: clock-like data pattern |
| shape_sel | input | 1 | Selects the variant of the clock and data words |
| payload | input | LANES*7 | Parallel payload, 7 bits per lane |
| lane_word | output | LANES*7 | Words to the serializer, lane i at [7*i+6:7*i] |
| clk_word | output | 7 | Word for the forwarded clock lane |
| drv_en | output | 1 | Output driver enable (0 tri-states the lanes) |
| train_busy | output | 1 | High while training runs |

## Verification
The bench builds the block with LANES=8 and TRAIN_CYCLES=24. The short training length lets complete runs in both modes and both shapes fit into a few hundred cycles. It also brings lock loss in the middle of training, restart pulses, and power-down within reach. The full eight-lane width confirms the payload slicing at every lane boundary. The 4096-cycle default differs only in the counter limit.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int WORD_W = 7;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_TRAIN = 2'd2,
    ST_RUN   = 2'd3
  } dsk_state_e;

  localparam word_t W_WIDE    = 7'b1111000;
  localparam word_t W_NARROW  = 7'b1110000;
  localparam word_t W_STRETCH = 7'b1111100;
  localparam word_t W_SHORT   = 7'b1100000;

  function automatic word_t idle_clk(input logic shape);
    return shape ? W_NARROW : W_WIDE;
  endfunction

  function automatic word_t train_clk(input logic mode, input logic shape);
    if (mode) return idle_clk(shape);
    return shape ? W_SHORT : W_STRETCH;
  endfunction

  function automatic word_t train_data(input logic mode, input logic shape,
                                       input logic phase);
    if (mode) return phase ? '0 : '1;
    return idle_clk(shape);
  endfunction
endpackage

// File: rtl/dsk_rst_sync.sv
module dsk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/dsk_ctrl.sv
module dsk_ctrl
  import dsk_pkg::*;
#(
  parameter int TRAIN_CYCLES = 4096,
  parameter int CNT_W        = $clog2(TRAIN_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_n,
  input  logic       pll_lock,
  input  logic       restart,
  output dsk_state_e state_o,
  output logic       phase_o,
  output logic       busy_o,
  output logic       drv_en_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRAIN_CYCLES - 1);

  dsk_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (!pwr_n) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_WAIT;
        ST_WAIT: begin
          if (pll_lock) begin
            state_d = ST_TRAIN;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end
        ST_TRAIN: begin
          if (!pll_lock || restart) begin
            state_d = ST_WAIT;
          end else if (cnt_q == LAST) begin
            state_d = ST_RUN;
          end else begin
            cnt_d  = cnt_q + CNT_W'(1);
            cnt_en = 1'b1;
          end
        end
        ST_RUN: begin
          if (!pll_lock || restart) state_d = ST_WAIT;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state_o  = state_q;
  assign phase_o  = cnt_q[0];
  assign busy_o   = (state_q == ST_TRAIN);
  assign drv_en_o = (state_q != ST_OFF);

  // R2: training is entered only after lock was sampled
  a_r2_lock_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(pll_lock) && $past(state_q) == ST_WAIT);

  // R3: counter starts at zero and steps by one while busy
  a_r3_cnt_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> cnt_q == '0);
  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cnt_q <= LAST);

  // R7: lock loss leaves training and payload mode
  a_r7_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIN || state_q == ST_RUN) && !pll_lock |=> !busy_o && state_q != ST_RUN);

  // R8: restart leaves training and payload mode
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIN || state_q == ST_RUN) && restart |=> !busy_o && state_q != ST_RUN);
endmodule

// File: rtl/dsk_pattern.sv
module dsk_pattern
  import dsk_pkg::*;
#(
  parameter int LANES = 8,
  localparam int PW   = LANES * WORD_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dsk_state_e state,
  input  logic       phase,
  input  logic       mode_sel,
  input  logic       shape_sel,
  input  logic [PW-1:0] payload,
  output logic [PW-1:0] lane_word,
  output word_t      clk_word
);
  always_comb begin
    unique case (state)
      ST_OFF:   clk_word = '0;
      ST_TRAIN: clk_word = train_clk(mode_sel, shape_sel);
      default:  clk_word = idle_clk(shape_sel);
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    word_t w;
    always_comb begin
      unique case (state)
        ST_TRAIN: w = train_data(mode_sel, shape_sel, phase);
        ST_RUN:   w = payload[g*WORD_W +: WORD_W];
        default:  w = '0;
      endcase
    end
    assign lane_word[g*WORD_W +: WORD_W] = w;

    // R9: three consecutive training words hold a transition
    a_r9_transition: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_TRAIN && $past(state) == ST_TRAIN && $past(state, 2) == ST_TRAIN
      |-> ({w, $past(w), $past(w, 2)} != '0) && ({w, $past(w), $past(w, 2)} != '1));
  end

  // R4: alternating mode flips every data word between all-ones and all-zeros
  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_TRAIN && $past(state) == ST_TRAIN && mode_sel && $past(mode_sel)
    |-> lane_word[WORD_W-1:0] == ~$past(lane_word[WORD_W-1:0]));
endmodule

// File: rtl/deskew_train_seq.sv
module deskew_train_seq
  import dsk_pkg::*;
#(
  parameter int LANES        = 8,
  parameter int TRAIN_CYCLES = 4096,
  localparam int PW          = LANES * 7,
  localparam int CNT_W       = $clog2(TRAIN_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic          pll_lock,
  input  logic          restart,
  input  logic          mode_sel,
  input  logic          shape_sel,
  input  logic [PW-1:0] payload,
  output logic [PW-1:0] lane_word,
  output logic [6:0]    clk_word,
  output logic          drv_en,
  output logic          train_busy
);
  logic       rst_sync_n;
  dsk_state_e state;
  logic       phase;

  dsk_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dsk_ctrl #(
    .TRAIN_CYCLES (TRAIN_CYCLES),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwr_n    (pwr_n),
    .pll_lock (pll_lock),
    .restart  (restart),
    .state_o  (state),
    .phase_o  (phase),
    .busy_o   (train_busy),
    .drv_en_o (drv_en)
  );

  dsk_pattern #(
    .LANES (LANES)
  ) u_pat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .state     (state),
    .phase     (phase),
    .mode_sel  (mode_sel),
    .shape_sel (shape_sel),
    .payload   (payload),
    .lane_word (lane_word),
    .clk_word  (clk_word)
  );

  // R1: power-down disables the drivers on the next cycle
  a_r1_pd_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pwr_n |=> !drv_en && !train_busy);

  // R1: disabled drivers carry all-zero words
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !drv_en |-> lane_word == '0 && clk_word == '0);

  // R6: payload words pass straight through outside training
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drv_en && !train_busy && lane_word != '0 |-> lane_word == payload);
endmodule

// File: tb/test_deskew_train_seq.sv
module test_deskew_train_seq;
  localparam int LANES = 8;
  localparam int TRN   = 24;
  localparam int PW    = LANES * 7;

  logic          clk = 1'b0;
  logic          rst_n, pwr_n, pll_lock, restart, mode_sel, shape_sel;
  logic [PW-1:0] payload;
  logic [PW-1:0] lane_word;
  logic [6:0]    clk_word;
  logic          drv_en, train_busy;

  always #2.5 clk = ~clk;

  deskew_train_seq #(.LANES(LANES), .TRAIN_CYCLES(TRN)) i_deskew_train_seq (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .pll_lock(pll_lock),
    .restart(restart), .mode_sel(mode_sel), .shape_sel(shape_sel),
    .payload(payload), .lane_word(lane_word), .clk_word(clk_word),
    .drv_en(drv_en), .train_busy(train_busy)
  );

  typedef struct {
    string         tag;
    int            st;
    logic [PW-1:0] lw;
    logic [6:0]    cw;
    logic          oe;
    logic          bz;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state: 0 off, 1 wait, 2 train, 3 run
  int m_st  = 0;
  int m_cnt = 0;
  bit s1 = 0, s2 = 0;

  always @(posedge clk) begin
    if (!s2 || !pwr_n) begin
      m_st = 0;
    end else begin
      case (m_st)
        0: m_st = 1;
        1: if (pll_lock) begin m_st = 2; m_cnt = 0; end
        2: begin
          if (!pll_lock || restart) m_st = 1;
          else if (m_cnt == TRN - 1) m_st = 3;
          else m_cnt = m_cnt + 1;
        end
        default: if (!pll_lock || restart) m_st = 1;
      endcase
    end
    s2 = s1;
    s1 = rst_n;
  end

  function automatic logic [6:0] idle_w(input logic sh);
    return sh ? 7'b1110000 : 7'b1111000;
  endfunction

  function automatic item_t make_exp(input string tag);
    item_t it;
    logic [6:0] dw;
    it.tag = tag; it.st = m_st;
    it.oe = (m_st != 0); it.bz = (m_st == 2);
    it.lw = '0; it.cw = '0;
    case (m_st)
      1: it.cw = idle_w(shape_sel);
      2: begin
        if (mode_sel) begin
          it.cw = idle_w(shape_sel);
          dw = (m_cnt % 2 == 0) ? 7'h7f : 7'h00;
        end else begin
          it.cw = shape_sel ? 7'b1100000 : 7'b1111100;
          dw = shape_sel ? 7'b1110000 : 7'b1111000;
        end
        for (int i = 0; i < LANES; i++) it.lw[i*7 +: 7] = dw;
      end
      3: begin
        it.cw = idle_w(shape_sel);
        it.lw = payload;
      end
      default: ;
    endcase
    return it;
  endfunction

  task automatic drive(input logic lk, input logic pw, input logic rs,
                       input logic md, input logic sh, input string tag);
    logic [63:0] r;
    @(negedge clk);
    r = {$urandom(), $urandom()};
    pll_lock = lk; pwr_n = pw; restart = rs; mode_sel = md; shape_sel = sh;
    payload = r[PW-1:0];
    exp_q.push_back(make_exp(tag));
  endtask

  // monitor / scoreboard
  int busy_len = 0;
  int hist_n   = 0;
  logic [6:0] h0, h1, h2;

  always @(negedge clk) begin
    item_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_cmp++;
      if (lane_word !== e.lw || clk_word !== e.cw || drv_en !== e.oe || train_busy !== e.bz) begin
        n_bad++;
        $display("FAIL %s: lanes=%h clk=%b en=%b busy=%b expected lanes=%h clk=%b en=%b busy=%b",
                 e.tag, lane_word, clk_word, drv_en, train_busy, e.lw, e.cw, e.oe, e.bz);
      end
      // R3: length of a completed busy run
      if (train_busy === 1'b1) busy_len++;
      else begin
        if (busy_len > 0 && e.st == 3) begin
          n_cmp++;
          if (busy_len != TRN) begin
            n_bad++;
            $display("FAIL R3: busy length %0d expected %0d", busy_len, TRN);
          end
        end
        busy_len = 0;
      end
      // R9: transition within three training cycles on lane 0
      if (e.st == 2) begin
        h2 = h1; h1 = h0; h0 = lane_word[6:0];
        hist_n++;
        if (hist_n >= 3) begin
          n_cmp++;
          if ({h2, h1, h0} == 21'h0 || {h2, h1, h0} == 21'h1fffff) begin
            n_bad++;
            $display("FAIL R9: stream %b expected a transition", {h2, h1, h0});
          end
        end
      end else hist_n = 0;
    end
  end

  initial begin
    rst_n = 0; pwr_n = 1; pll_lock = 0; restart = 0;
    mode_sel = 1; shape_sel = 0; payload = '0;
    for (int k = 0; k < 3; k++) drive(0, 1, 0, 1, 0, "R1 reset");
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 6; k++) drive(0, 1, 0, 1, 0, "R2 wait for lock");
    // mode 1, shape 0: full training then payload
    for (int k = 0; k < TRN + 1; k++) drive(1, 1, 0, 1, 0, "R4 alternating training");
    for (int k = 0; k < 8; k++) drive(1, 1, 0, 1, 0, "R6 payload");
    // lock loss in payload mode
    for (int k = 0; k < 3; k++) drive(0, 1, 0, 1, 0, "R7 lock lost in run");
    // mode 0, shape 1; lock lost mid-training
    for (int k = 0; k < 10; k++) drive(1, 1, 0, 0, 1, "R5 clock-like training");
    for (int k = 0; k < 2; k++) drive(0, 1, 0, 0, 1, "R7 lock lost in training");
    for (int k = 0; k < TRN + 1; k++) drive(1, 1, 0, 0, 1, "R5 clock-like training");
    for (int k = 0; k < 6; k++) drive(1, 1, 0, 0, 1, "R6 payload shape 1");
    // restart in payload mode and during training
    drive(1, 1, 1, 1, 1, "R8 restart in run");
    for (int k = 0; k < 7; k++) drive(1, 1, 0, 1, 1, "R8 retrain");
    drive(1, 1, 1, 1, 1, "R8 restart in training");
    for (int k = 0; k < TRN + 3; k++) drive(1, 1, 0, 1, 1, "R8 full retrain");
    // power-down
    for (int k = 0; k < 4; k++) drive(1, 0, 0, 0, 0, "R1 power-down");
    for (int k = 0; k < TRN + 3; k++) drive(1, 1, 0, 0, 0, "R5 training after power-up");
    for (int k = 0; k < 6; k++) drive(1, 1, 0, 0, 0, "R6 payload shape 0");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule